// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Engine

This block runs a single host-side programmed-I/O transfer on a parallel ATA bus. A request names the direction, whether it touches an 8-bit taskfile register or the 16-bit data port, a 3-bit device address and which chip select to assert. The engine then places the address, pulses the read or write strobe, optionally stretches that strobe while the device holds IORDY low, and closes with a recovery gap. Read data comes back on a result port, and a one-clock done pulse marks the end of the transfer.

Every duration is counted in clock ticks and is set by configuration inputs. There is one setup count, plus two sets of active, cycle and recovery counts: one for register accesses and one for data accesses. The engine also converts the PIO mode number into the number of clocks that write data stays on the bus after the write strobe rises. It reports this count on a port and uses it itself.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset and whenever no transfer is running, `ata_cs0_n`, `ata_cs1_n`, `ata_dior_n` and `ata_diow_n` are all 1, `ata_dd_oe`, `busy` and `done` are 0.
- R2: For the whole transfer, `ata_da` equals the requested address. `req_alt_cs`=0 gives `ata_cs0_n`=0 and `ata_cs1_n`=1. `req_alt_cs`=1 gives `ata_cs0_n`=1 and `ata_cs1_n`=0. This is the 5-bit bus word {A2,A1,A0,CS1N,CS0N}.
- R3: A request seen while idle starts a transfer at the next edge. Both strobes stay high for max(setup,1) cycles. Then DIOR- (read, `req_write`=0) or DIOW- (write, `req_write`=1) goes low for at least max(active,1) cycles. The strobes are never low together.
- R4: `rd_data` holds the value `ata_dd_in` had in the last cycle before DIOR- rises.
- R5: On a write, `ata_dd_oe`=1 and `ata_dd_out` equals the write data while DIOW- is low. Both also continue for the first `hold_clks` recovery cycles, cut short if recovery ends first.
- R6: `hold_clks` is 3 for PIO mode 0, 2 for modes 1 and 2, and 1 for mode 3 and above.
- R7: `req_reg`=1 selects the register timing set and `req_reg`=0 selects the data timing set. The setup count is shared by both.
- R8: Let n be the number of cycles the strobe was low. Recovery lasts (cycle−n) cycles if cycle>n and cycle−n>recover. Otherwise it lasts recover cycles. In both cases it lasts at least 1 cycle.
- R9: With `cfg_iordy_en`=1, once the active count is reached the strobe stays low while `ata_iordy` is 0. The total low time is capped at max(active, 51) cycles, where 51 = (1250+35)/25.
- R10: `iordy_timeout` is cleared when a transfer starts. It is set when the strobe is released at the cap while `ata_iordy` is still 0, and it holds until the next start. The transfer still completes.
- R11: `done` is high for exactly the last recovery cycle. The engine is idle in the following cycle.
- R12: A request that arrives while `busy`=1 is ignored and does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transfer (sampled while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = register timing set, 0 = data timing set |
| req_addr | input | 3 | Device register address |
| req_alt_cs | input | 1 | 1 = assert CS1-, 0 = assert CS0- |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | CNT_W | Address setup ticks |
| cfg_reg_active | input | CNT_W | Register strobe ticks |
| cfg_reg_cycle | input | CNT_W | Register minimum cycle ticks |
| cfg_reg_recover | input | CNT_W | Register minimum recovery ticks |
| cfg_dat_active | input | CNT_W | Data strobe ticks |
| cfg_dat_cycle | input | CNT_W | Data minimum cycle ticks |
| cfg_dat_recover | input | CNT_W | Data minimum recovery ticks |
| cfg_iordy_en | input | 1 | Enable IORDY stretching |
| cfg_pio_mode | input | 3 | PIO mode number |
| hold_clks | output | 2 | Write data hold clocks for the mode |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready |
| ata_dd_in | input | DATA_W | Data bus input |
| ata_dd_out | output | DATA_W | Data bus output |
| ata_dd_oe | output | 1 | Data bus output enable |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | Transfer finished (one clock) |
| busy | output | 1 | Transfer in progress |
| iordy_timeout | output | 1 | IORDY cap reached with IORDY low |

## Verification
The assertions assume that `ata_iordy` and `ata_dd_in` are already synchronous to `clk`. They also assume that configuration inputs are steady when a request is accepted, because the engine latches them then. The stimulus changes `ata_iordy` and `ata_dd_in` only between clock edges. It sets every configuration value while the engine is idle. It drives `ata_dd_in` with the expected value only in the last strobe-low cycle, so a capture one cycle early or late is caught. The cycle-accurate model predicts the stretch length from the number of cycles the bench keeps IORDY low. It also covers the cases where the cap is reached and where the active count already exceeds the cap.

// File: rtl/pio_cycle_pkg.sv
package pio_cycle_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } pio_phase_e;

    // Latched request attributes that shape the bus lines.
    typedef struct packed {
        logic       write;
        logic [2:0] dev_addr;
        logic       alt_cs;
    } pio_req_t;

    localparam int unsigned BUS_WORD_W = 5;

    // Data-bus hold after DIOW- rises, in clocks, per PIO mode.
    function automatic logic [1:0] wr_hold_clocks(input logic [2:0] mode);
        logic [1:0] h;
        case (mode)
            3'd0:       h = 2'd3;
            3'd1, 3'd2: h = 2'd2;
            default:    h = 2'd1;
        endcase
        return h;
    endfunction

    // Bus word {A2,A1,A0,CS1N,CS0N}: primary select clears CS0N, alternate clears CS1N.
    function automatic logic [BUS_WORD_W-1:0] bus_word(input pio_req_t r);
        return {r.dev_addr, ~r.alt_cs, r.alt_cs};
    endfunction

endpackage

// File: rtl/pio_timing_pick.sv
module pio_timing_pick #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             regsel,
    input  logic [CNT_W-1:0] reg_active,
    input  logic [CNT_W-1:0] reg_cycle,
    input  logic [CNT_W-1:0] reg_recover,
    input  logic [CNT_W-1:0] dat_active,
    input  logic [CNT_W-1:0] dat_cycle,
    input  logic [CNT_W-1:0] dat_recover,
    output logic [CNT_W-1:0] sel_active,
    output logic [CNT_W-1:0] sel_cycle,
    output logic [CNT_W-1:0] sel_recover
);
    always_comb begin
        if (regsel) begin
            sel_active  = reg_active;
            sel_cycle   = reg_cycle;
            sel_recover = reg_recover;
        end else begin
            sel_active  = dat_active;
            sel_cycle   = dat_cycle;
            sel_recover = dat_recover;
        end
    end
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
    import pio_cycle_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned IORDY_TICKS = 51
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] active_i,
    input  logic [CNT_W-1:0] cycle_i,
    input  logic [CNT_W-1:0] recover_i,
    input  logic [1:0]       hold_i,
    input  logic             iordy_en_i,
    input  logic             iordy_i,
    output pio_phase_e       phase_o,
    output logic             accept_o,
    output logic             strobe_end_o,
    output logic             hold_win_o,
    output logic             done_o,
    output logic             timeout_o
);
    localparam int unsigned EW = CNT_W + 1;
    localparam logic [EW-1:0] LIMIT = EW'(IORDY_TICKS);

    pio_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] setup_q, active_q, cycle_q, recover_q;
    logic [1:0]       hold_q;
    logic             chk_q;
    logic [EW-1:0]    wait_q;
    logic             to_q;

    function automatic logic [EW-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? EW'(1) : {1'b0, v};
    endfunction

    logic [EW-1:0] tick, setup_len, active_len, cap_len, span, wlen, wait_next;
    logic          base_done, stalled, at_cap, leave, expire, rec_last;

    always_comb begin
        tick       = {1'b0, cnt_q} + EW'(1);
        setup_len  = at_least_one(setup_q);
        active_len = at_least_one(active_q);
        cap_len    = (active_len > LIMIT) ? active_len : LIMIT;
        base_done  = tick >= active_len;
        stalled    = chk_q && !iordy_i;
        at_cap     = tick >= cap_len;
        leave      = (phase_q == PH_ACTIVE) && base_done && (!stalled || at_cap);
        expire     = leave && stalled;
        span       = {1'b0, cycle_q} - tick;
        wlen       = (({1'b0, cycle_q} > tick) && (span > {1'b0, recover_q}))
                     ? span : {1'b0, recover_q};
        wait_next  = (wlen == '0) ? EW'(1) : wlen;
        rec_last   = tick >= wait_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            setup_q   <= '0;
            active_q  <= '0;
            cycle_q   <= '0;
            recover_q <= '0;
            hold_q    <= 2'd1;
            chk_q     <= 1'b0;
            wait_q    <= EW'(1);
            to_q      <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        setup_q   <= setup_i;
                        active_q  <= active_i;
                        cycle_q   <= cycle_i;
                        recover_q <= recover_i;
                        hold_q    <= hold_i;
                        chk_q     <= iordy_en_i;
                        to_q      <= 1'b0;
                        cnt_q     <= '0;
                        phase_q   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (tick >= setup_len) begin
                        cnt_q   <= '0;
                        phase_q <= PH_ACTIVE;
                    end else begin
                        cnt_q <= tick[CNT_W-1:0];
                    end
                end
                PH_ACTIVE: begin
                    if (leave) begin
                        cnt_q   <= '0;
                        wait_q  <= wait_next;
                        to_q    <= expire;
                        phase_q <= PH_RECOVER;
                    end else begin
                        cnt_q <= tick[CNT_W-1:0];
                    end
                end
                default: begin
                    if (rec_last) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= tick[CNT_W-1:0];
                    end
                end
            endcase
        end
    end

    assign phase_o      = phase_q;
    assign accept_o     = (phase_q == PH_IDLE) && req_i;
    assign strobe_end_o = leave;
    assign hold_win_o   = (phase_q == PH_RECOVER) &&
                          (cnt_q < {{(CNT_W-2){1'b0}}, hold_q});
    assign done_o       = (phase_q == PH_RECOVER) && rec_last;
    assign timeout_o    = to_q;
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
    import pio_cycle_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  pio_phase_e        phase,
    input  pio_req_t          req_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              hold_win,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe
);
    logic [BUS_WORD_W-1:0] word;
    logic                  live, strobing;

    always_comb begin
        live     = (phase != PH_IDLE);
        strobing = (phase == PH_ACTIVE);
        word     = live ? bus_word(req_q) : {3'b000, 2'b11};
        cs0_n    = word[0];
        cs1_n    = word[1];
        da       = word[4:2];
        dior_n   = !(strobing && !req_q.write);
        diow_n   = !(strobing && req_q.write);
        dd_oe    = req_q.write && (strobing || hold_win);
        dd_out   = dd_oe ? wdata_q : '0;
    end
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
    import pio_cycle_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned STRETCH_NS = 1250,
    parameter int unsigned SAMPLE_NS  = 35,
    parameter int unsigned TICK_NS    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic [2:0]        req_addr,
    input  logic              req_alt_cs,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_reg_active,
    input  logic [CNT_W-1:0]  cfg_reg_cycle,
    input  logic [CNT_W-1:0]  cfg_reg_recover,
    input  logic [CNT_W-1:0]  cfg_dat_active,
    input  logic [CNT_W-1:0]  cfg_dat_cycle,
    input  logic [CNT_W-1:0]  cfg_dat_recover,
    input  logic              cfg_iordy_en,
    input  logic [2:0]        cfg_pio_mode,
    output logic [1:0]        hold_clks,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    input  logic              ata_iordy,
    input  logic [DATA_W-1:0] ata_dd_in,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    output logic              iordy_timeout
);
    localparam int unsigned IORDY_TICKS = (STRETCH_NS + SAMPLE_NS) / TICK_NS;

    logic [CNT_W-1:0] pick_active, pick_cycle, pick_recover;
    pio_phase_e       phase;
    logic             accept, strobe_end, hold_win;
    pio_req_t         req_q;
    logic [DATA_W-1:0] wdata_q;

    assign hold_clks = wr_hold_clocks(cfg_pio_mode);

    pio_timing_pick #(.CNT_W(CNT_W)) pick_i (
        .regsel      (req_reg),
        .reg_active  (cfg_reg_active),
        .reg_cycle   (cfg_reg_cycle),
        .reg_recover (cfg_reg_recover),
        .dat_active  (cfg_dat_active),
        .dat_cycle   (cfg_dat_cycle),
        .dat_recover (cfg_dat_recover),
        .sel_active  (pick_active),
        .sel_cycle   (pick_cycle),
        .sel_recover (pick_recover)
    );

    pio_cycle_fsm #(.CNT_W(CNT_W), .IORDY_TICKS(IORDY_TICKS)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .setup_i      (cfg_setup),
        .active_i     (pick_active),
        .cycle_i      (pick_cycle),
        .recover_i    (pick_recover),
        .hold_i       (hold_clks),
        .iordy_en_i   (cfg_iordy_en),
        .iordy_i      (ata_iordy),
        .phase_o      (phase),
        .accept_o     (accept),
        .strobe_end_o (strobe_end),
        .hold_win_o   (hold_win),
        .done_o       (done),
        .timeout_o    (iordy_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            if (accept) begin
                req_q.write    <= req_write;
                req_q.dev_addr <= req_addr;
                req_q.alt_cs   <= req_alt_cs;
                wdata_q        <= req_wdata;
            end
            if (strobe_end && !req_q.write)
                rd_data <= ata_dd_in;
        end
    end

    pio_bus_drive #(.DATA_W(DATA_W)) drive_i (
        .phase    (phase),
        .req_q    (req_q),
        .wdata_q  (wdata_q),
        .hold_win (hold_win),
        .cs0_n    (ata_cs0_n),
        .cs1_n    (ata_cs1_n),
        .da       (ata_da),
        .dior_n   (ata_dior_n),
        .diow_n   (ata_diow_n),
        .dd_out   (ata_dd_out),
        .dd_oe    (ata_dd_oe)
    );

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cs0_n,
    input logic              cs1_n,
    input logic [2:0]        da,
    input logic              dior_n,
    input logic              diow_n,
    input logic              dd_oe,
    input logic [DATA_W-1:0] dd_in,
    input logic [DATA_W-1:0] rd_data
);
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs0_n && cs1_n && dior_n && diow_n && !dd_oe));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({cs0_n, cs1_n, da}));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    // R3
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dior_n) || $fell(diow_n)) |-> $past(busy));

    // R4
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dior_n) |-> (rd_data == $past(dd_in)));

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !diow_n |-> dd_oe);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R11
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind pio_cycle_engine pio_cycle_engine_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .cs0_n   (ata_cs0_n),
    .cs1_n   (ata_cs1_n),
    .da      (ata_da),
    .dior_n  (ata_dior_n),
    .diow_n  (ata_diow_n),
    .dd_oe   (ata_dd_oe),
    .dd_in   (ata_dd_in),
    .rd_data (rd_data)
);

// File: tb/pio_cycle_engine_tb.sv
module pio_cycle_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_write = 1'b0, req_reg = 1'b0, req_alt_cs = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [15:0] req_wdata = 16'h0;
    logic [7:0]  cfg_setup = 8'd1;
    logic [7:0]  cfg_reg_active = 8'd1, cfg_reg_cycle = 8'd1, cfg_reg_recover = 8'd1;
    logic [7:0]  cfg_dat_active = 8'd1, cfg_dat_cycle = 8'd1, cfg_dat_recover = 8'd1;
    logic        cfg_iordy_en = 1'b0;
    logic [2:0]  cfg_pio_mode = 3'd0;
    logic [1:0]  hold_clks;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [2:0]  ata_da;
    logic        ata_iordy = 1'b1;
    logic [15:0] ata_dd_in = 16'h0;
    logic [15:0] ata_dd_out, rd_data;
    logic        done, busy, iordy_timeout;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pio_cycle_engine dut_i (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_reg(req_reg),
        .req_addr(req_addr), .req_alt_cs(req_alt_cs), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_reg_active(cfg_reg_active),
        .cfg_reg_cycle(cfg_reg_cycle), .cfg_reg_recover(cfg_reg_recover),
        .cfg_dat_active(cfg_dat_active), .cfg_dat_cycle(cfg_dat_cycle),
        .cfg_dat_recover(cfg_dat_recover), .cfg_iordy_en(cfg_iordy_en),
        .cfg_pio_mode(cfg_pio_mode), .hold_clks(hold_clks),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_iordy(ata_iordy),
        .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
        .rd_data(rd_data), .done(done), .busy(busy), .iordy_timeout(iordy_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 busy"}, int'(busy), 0);
        chk({tag, " R1 lines"}, int'({ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}), 15);
        chk({tag, " R1 oe"}, int'(ata_dd_oe), 0);
        chk({tag, " R11 done"}, int'(done), 0);
    endtask

    task automatic set_timing(input int s, input int ra, input int rc, input int rr,
                              input int da, input int dc, input int dr);
        cfg_setup       = 8'(s);
        cfg_reg_active  = 8'(ra); cfg_reg_cycle = 8'(rc); cfg_reg_recover = 8'(rr);
        cfg_dat_active  = 8'(da); cfg_dat_cycle = 8'(dc); cfg_dat_recover = 8'(dr);
    endtask

    // Reference model: predicts every cycle of one transfer and compares.
    task automatic xfer(input bit wr, input bit rg, input int a, input bit alt,
                        input int wd, input int rdval, input int k_low, input bit spur);
        int s, act, cyc, rec, lim, n, w, hold, total, to;
        s   = (cfg_setup == 0) ? 1 : int'(cfg_setup);
        act = rg ? int'(cfg_reg_active) : int'(cfg_dat_active);
        cyc = rg ? int'(cfg_reg_cycle) : int'(cfg_dat_cycle);
        rec = rg ? int'(cfg_reg_recover) : int'(cfg_dat_recover);
        if (act == 0) act = 1;
        lim = (act > 51) ? act : 51;
        n   = act;
        to  = 0;
        if (cfg_iordy_en) begin
            if (k_low + 1 > n) n = k_low + 1;
            if (n > lim) n = lim;
            if (k_low >= lim) to = 1;
        end
        w = (cyc > n && cyc - n > rec) ? cyc - n : rec;
        if (w == 0) w = 1;
        hold  = (cfg_pio_mode == 0) ? 3 : (cfg_pio_mode < 3) ? 2 : 1;
        total = s + n + w;

        @(negedge clk);
        req = 1'b1; req_write = wr; req_reg = rg; req_addr = 3'(a);
        req_alt_cs = alt; req_wdata = 16'(wd);
        @(negedge clk);
        req = 1'b0;
        for (int t = 1; t <= total; t++) begin
            bit in_act, in_rec;
            int r, exp_oe;
            in_act = (t > s) && (t <= s + n);
            in_rec = (t > s + n);
            r = t - s - n;
            exp_oe = (wr && (in_act || (in_rec && r - 1 < hold))) ? 1 : 0;
            chk("R11 busy", int'(busy), 1);
            chk("R2 cs0_n", int'(ata_cs0_n), alt ? 1 : 0);
            chk("R2 cs1_n", int'(ata_cs1_n), alt ? 0 : 1);
            chk("R2 da", int'(ata_da), a);
            chk("R3 dior_n", int'(ata_dior_n), (in_act && !wr) ? 0 : 1);
            chk("R3 diow_n", int'(ata_diow_n), (in_act && wr) ? 0 : 1);
            chk("R5 dd_oe", int'(ata_dd_oe), exp_oe);
            if (exp_oe == 1) chk("R5 dd_out", int'(ata_dd_out), wd & 16'hFFFF);
            chk("R11 done", int'(done), (in_rec && r == w) ? 1 : 0);
            chk("R10 timeout", int'(iordy_timeout), in_rec ? to : 0);
            if (!wr && in_rec) chk("R4 rd_data", int'(rd_data), rdval);
            // inputs for this cycle
            ata_iordy = (in_act && (t - s) <= k_low) ? 1'b0 : 1'b1;
            ata_dd_in = (t == s + n) ? 16'(rdval) : ~16'(rdval);
            if (spur && t == 2) begin
                req = 1'b1; req_addr = 3'(a ^ 5); req_write = ~wr; req_alt_cs = ~alt;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        ata_iordy = 1'b1;
        chk_idle("end R12");
        if (!wr) chk("R4 rd_data held", int'(rd_data), rdval);
        chk("R10 timeout held", int'(iordy_timeout), to);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("post-reset");

        // R6 hold mapping for every mode value
        for (int m = 0; m < 8; m++) begin
            cfg_pio_mode = 3'(m);
            #1;
            chk("R6 hold_clks", int'(hold_clks), (m == 0) ? 3 : (m < 3) ? 2 : 1);
        end

        cfg_pio_mode = 3'd0;
        cfg_iordy_en = 1'b0;
        set_timing(2, 3, 8, 2, 4, 6, 3);
        xfer(0, 1, 7, 0, 0, 16'h00A5, 0, 0);          // R8 cycle-based recovery, R7 register set
        xfer(1, 0, 0, 0, 16'hBEEF, 0, 0, 0);          // R7 data set, R5 hold 3
        cfg_pio_mode = 3'd3;
        xfer(1, 1, 2, 0, 16'h1234, 0, 0, 0);          // R5 hold 1
        cfg_pio_mode = 3'd1;
        xfer(0, 1, 6, 1, 0, 16'h5A3C, 0, 0);          // R2 alternate select
        set_timing(2, 3, 8, 2, 2, 20, 3);
        xfer(0, 0, 0, 0, 0, 16'hC3C3, 0, 0);          // R8 long data cycle
        cfg_pio_mode = 3'd0;
        set_timing(0, 0, 0, 0, 0, 0, 0);
        xfer(1, 1, 5, 1, 16'h0F0F, 0, 0, 0);          // R3 zero counts, R5 hold cut
        set_timing(3, 4, 12, 2, 2, 5, 2);
        xfer(1, 0, 0, 0, 16'h7E7E, 0, 0, 1);          // R12 request while busy
        xfer(0, 1, 4, 0, 0, 16'h9999, 0, 1);          // R12 on a read

        cfg_iordy_en = 1'b1;
        set_timing(1, 2, 4, 1, 2, 4, 1);
        xfer(0, 1, 7, 0, 0, 16'h1111, 5, 0);          // R9 stretch
        xfer(0, 1, 7, 0, 0, 16'h2222, 100, 0);        // R9 cap, R10 timeout
        xfer(1, 0, 0, 0, 16'h3333, 0, 0, 0);          // R10 cleared
        set_timing(1, 60, 62, 1, 2, 4, 1);
        xfer(0, 1, 1, 0, 0, 16'h4444, 100, 0);        // R9 active above cap, R10
        xfer(0, 1, 1, 0, 0, 16'h5555, 10, 0);         // R9 no stretch needed

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog R11 actual=busy expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule